// File: doc/BRIEF.md
# Prescaled Dual Down-Counter Timer

This block gives a processor two 32-bit down-counting timers driven by one shared prescaler. The prescaler counts system clocks down to zero, reloads itself and emits a single-cycle tick. Every tick moves each enabled timer one step toward zero. A timer at zero underflows on the next tick instead of decrementing. On underflow it raises a sticky pending flag. It then either reloads from its reload register (restart mode) or switches itself off (one-shot mode). The second timer can be chained so that it only counts while the first timer's pending flag is set.

Software reaches the block through a plain single-cycle register port. A write takes effect on the clock edge where `bus_we` is high. Read data is combinational from `bus_addr`, and reads have no side effects. The port has no handshake: every access completes in one cycle and cannot be stalled. Each timer drives its own interrupt line, which pulses for one clock when that timer underflows with its interrupt enable set.

The address map uses byte offsets:

| Offset | Register |
|--------|----------|
| 0x00 | prescaler value |
| 0x04 | prescaler reload |
| 0x08 | configuration word |
| 0x10 | timer 1 counter |
| 0x14 | timer 1 reload |
| 0x18 | timer 1 control |
| 0x1C | timer 1 latch |
| 0x20 to 0x2C | the same four registers for timer 2 |

Control bits are: bit 0 enable, bit 1 restart, bit 2 load, bit 3 interrupt enable, bit 4 pending, bit 5 chain.

Top module: `ptmr_unit`

## Requirements
- R1: The prescaler value decrements once per clock. In a cycle where it is zero it produces one tick and reloads from the prescaler reload register, so ticks recur every reload+1 clocks. A write to offset 0x00 replaces the value.
- R2: On a tick, a timer with enable (bit 0) set and a nonzero counter decrements by one. A disabled timer's counter holds.
- R3: On a tick, an enabled timer whose counter is zero underflows and sets pending (bit 4). With restart (bit 1) set it reloads the counter from its reload register.
- R4: An underflow with restart clear clears the timer's own enable bit, and the counter stays at zero.
- R5: With chain (bit 5) set, timer 2 acts on ticks only while timer 1's pending bit is 1. The chain bit of timer 1 has no effect.
- R6: A control write with load (bit 2) at 1 copies the reload register into the counter. Bit 2 always reads as 0.
- R7: A control write with bit 4 at 0 clears pending, and one with bit 4 at 1 leaves pending unchanged. Software can never set pending. Bits 0, 1, 3 and 5 take the written value.
- R8: Any write to a timer's latch register stores that timer's current counter value in the latch. The write data is discarded.
- R9: Configuration bits [2:0] read 2 and bits [7:3] read 8, so the low byte is 0x42. Only bits [31:8] are writable.
- R10: After reset, prescaler value and reload both read 39, all timer registers read 0, and both interrupt outputs are low.
- R11: A timer's interrupt output is high for one clock, on the cycle after an underflow edge, when its interrupt enable (bit 3) is set. It stays low when interrupt enable is clear.
- R12: Offsets outside the map read 0. A control or counter write to a timer takes precedence over that timer's tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe, one write per high cycle |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| tmr_irq | output | 2 | Per-timer underflow interrupt pulse, bit 0 is timer 1 |

## Verification
On every cycle the embedded assertions check the following:
- the prescaler reloads after reaching zero;
- an enabled counter steps down by exactly one per tick;
- a one-shot underflow drops its enable;
- a blocked chained timer holds still;
- a control write with bit 4 at 0 always clears pending;
- an interrupt pulse is always accompanied by a set pending flag.

Only the bench scenarios can show the remaining behaviours:
- whole periods, meaning the spacing between interrupt pulses under a nonzero prescaler and pulse counts in restart mode;
- the register-level effects of load, latch and the read-only configuration byte;
- chained counting starting only once timer 1 underflows.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 8;

  // control bit positions (the bus layout software relies on)
  localparam int unsigned CB_EN    = 0;
  localparam int unsigned CB_RS    = 1;
  localparam int unsigned CB_LD    = 2;
  localparam int unsigned CB_IE    = 3;
  localparam int unsigned CB_IP    = 4;
  localparam int unsigned CB_CHAIN = 5;

  typedef struct packed {
    logic chain;
    logic ip;
    logic ie;
    logic rs;
    logic en;
  } tctl_t;

  function automatic logic [DW-1:0] ctl_word(input tctl_t c);
    logic [DW-1:0] w;
    w = '0;
    w[CB_EN]    = c.en;
    w[CB_RS]    = c.rs;
    w[CB_IE]    = c.ie;
    w[CB_IP]    = c.ip;
    w[CB_CHAIN] = c.chain;
    return w;
  endfunction
endpackage

// File: rtl/ptmr_prescale.sv
module ptmr_prescale
  import ptmr_pkg::*;
#(
  parameter logic [DW-1:0] RST_VAL = 32'd39
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_val_i,
  input  logic          wr_rld_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] val_o,
  output logic [DW-1:0] rld_o,
  output logic          tick_o
);
  logic [DW-1:0] val_q, rld_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val_q <= RST_VAL;
      rld_q <= RST_VAL;
    end else begin
      if (wr_val_i)          val_q <= wdata_i;
      else if (val_q == '0)  val_q <= rld_q;
      else                   val_q <= val_q - 1'b1;
      if (wr_rld_i)          rld_q <= wdata_i;
    end
  end

  assign tick_o = (val_q == '0);
  assign val_o  = val_q;
  assign rld_o  = rld_q;

  // R1
  presc_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && !wr_val_i) |=> (val_q == $past(rld_q)));
endmodule

// File: rtl/ptmr_chan.sv
module ptmr_chan
  import ptmr_pkg::*;
#(
  parameter bit CHAIN_OK = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          gate_i,
  input  logic          wr_cnt_i,
  input  logic          wr_rld_i,
  input  logic          wr_ctl_i,
  input  logic          wr_lat_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] cnt_o,
  output logic [DW-1:0] rld_o,
  output logic [DW-1:0] ctl_o,
  output logic [DW-1:0] lat_o,
  output logic          ip_o,
  output logic          irq_o
);
  logic [DW-1:0] cnt_q, rld_q, lat_q;
  tctl_t         ctl_q;
  logic          irq_q;
  logic          blocked, act, at_zero;

  generate
    if (CHAIN_OK) begin : g_chain
      assign blocked = ctl_q.chain && !gate_i;
    end else begin : g_free
      assign blocked = 1'b0;
    end
  endgenerate

  assign act     = tick_i && ctl_q.en && !blocked;
  assign at_zero = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rld_q <= '0;
      lat_q <= '0;
      ctl_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (wr_cnt_i) begin
        cnt_q <= wdata_i;
      end else if (wr_ctl_i) begin
        ctl_q.en    <= wdata_i[CB_EN];
        ctl_q.rs    <= wdata_i[CB_RS];
        ctl_q.ie    <= wdata_i[CB_IE];
        ctl_q.chain <= wdata_i[CB_CHAIN];
        if (!wdata_i[CB_IP]) ctl_q.ip <= 1'b0;
        if (wdata_i[CB_LD])  cnt_q    <= rld_q;
      end else if (act) begin
        if (at_zero) begin
          ctl_q.ip <= 1'b1;
          irq_q    <= ctl_q.ie;
          if (ctl_q.rs) cnt_q    <= rld_q;
          else          ctl_q.en <= 1'b0;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
      if (wr_rld_i) rld_q <= wdata_i;
      if (wr_lat_i) lat_q <= cnt_q;
    end
  end

  assign cnt_o = cnt_q;
  assign rld_o = rld_q;
  assign ctl_o = ctl_word(ctl_q);
  assign lat_o = lat_q;
  assign ip_o  = ctl_q.ip;
  assign irq_o = irq_q;

  // R2
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && ctl_q.en && !blocked && !at_zero && !wr_cnt_i && !wr_ctl_i)
      |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R4
  oneshot_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act && at_zero && !ctl_q.rs && !wr_cnt_i && !wr_ctl_i) |=> !ctl_q.en);
  // R5
  chain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (CHAIN_OK && ctl_q.chain && !gate_i && !wr_cnt_i && !wr_ctl_i) |=> $stable(cnt_q));
  // R7
  ip_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl_i && !wdata_i[CB_IP]) |=> !ctl_q.ip);
  // R11
  irq_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> ctl_q.ip);
endmodule

// File: rtl/ptmr_unit.sv
module ptmr_unit
  import ptmr_pkg::*;
#(
  parameter logic [DW-1:0] PRESC_RST = 32'd39,
  parameter int unsigned   IRQ_NUM   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [1:0]    tmr_irq
);
  localparam int unsigned NT = 2;
  localparam logic [7:0]  CFG_LOW = {IRQ_NUM[4:0], NT[2:0]};

  logic [DW-1:0] pv, prl;
  logic          tick;
  logic [DW-9:0] cfg_hi_q;

  logic [DW-1:0] cnt [NT];
  logic [DW-1:0] rld [NT];
  logic [DW-1:0] ctl [NT];
  logic [DW-1:0] lat [NT];
  logic [NT-1:0] ip, irq;

  ptmr_prescale #(.RST_VAL(PRESC_RST)) u_presc (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_val_i (bus_we && bus_addr == 8'h00),
    .wr_rld_i (bus_we && bus_addr == 8'h04),
    .wdata_i  (bus_wdata),
    .val_o    (pv),
    .rld_o    (prl),
    .tick_o   (tick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                          cfg_hi_q <= '0;
    else if (bus_we && bus_addr == 8'h08) cfg_hi_q <= bus_wdata[DW-1:8];
  end

  genvar gi;
  generate
    for (gi = 0; gi < NT; gi++) begin : g_tmr
      localparam logic [3:0] SLOT = 4'(gi + 1);
      logic sel;
      assign sel = bus_we && (bus_addr[7:4] == SLOT);
      ptmr_chan #(.CHAIN_OK(gi > 0)) u_chan (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick),
        .gate_i   (gi > 0 ? ip[0] : 1'b1),
        .wr_cnt_i (sel && bus_addr[3:0] == 4'h0),
        .wr_rld_i (sel && bus_addr[3:0] == 4'h4),
        .wr_ctl_i (sel && bus_addr[3:0] == 4'h8),
        .wr_lat_i (sel && bus_addr[3:0] == 4'hC),
        .wdata_i  (bus_wdata),
        .cnt_o    (cnt[gi]),
        .rld_o    (rld[gi]),
        .ctl_o    (ctl[gi]),
        .lat_o    (lat[gi]),
        .ip_o     (ip[gi]),
        .irq_o    (irq[gi])
      );
    end
  endgenerate

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      8'h00: bus_rdata = pv;
      8'h04: bus_rdata = prl;
      8'h08: bus_rdata = {cfg_hi_q, CFG_LOW};
      8'h10: bus_rdata = cnt[0];
      8'h14: bus_rdata = rld[0];
      8'h18: bus_rdata = ctl[0];
      8'h1C: bus_rdata = lat[0];
      8'h20: bus_rdata = cnt[1];
      8'h24: bus_rdata = rld[1];
      8'h28: bus_rdata = ctl[1];
      8'h2C: bus_rdata = lat[1];
      default: bus_rdata = '0;
    endcase
  end

  assign tmr_irq = irq;

  // R9
  cfg_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 8'h08) |-> (bus_rdata[7:0] == 8'h42));
endmodule

// File: tb/ptmr_unit_tb.sv
`timescale 1ns/1ps
module ptmr_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  tmr_irq;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  ptmr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_irq(tmr_irq)
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  a;
    logic [31:0] d;
    logic [31:0] e;
    logic [7:0]  req;
  } vec_t;

  // register-level vectors; prescaler is parked far from zero first
  localparam vec_t VEC [0:17] = '{
    '{1'b1, 8'h04, 32'h00FFFFFF, 32'h0, 8'd1},
    '{1'b1, 8'h00, 32'h00FFFFFF, 32'h0, 8'd1},
    '{1'b0, 8'h04, 32'h0, 32'h00FFFFFF, 8'd1},   // R1 reload readback
    '{1'b0, 8'h08, 32'h0, 32'h00000042, 8'd9},   // R9
    '{1'b1, 8'h08, 32'hAABBCCFF, 32'h0, 8'd9},
    '{1'b0, 8'h08, 32'h0, 32'hAABBCC42, 8'd9},   // R9 low byte read-only
    '{1'b1, 8'h14, 32'h12345678, 32'h0, 8'd12},
    '{1'b0, 8'h14, 32'h0, 32'h12345678, 8'd12},  // R12 map
    '{1'b1, 8'h10, 32'h00000055, 32'h0, 8'd12},
    '{1'b0, 8'h10, 32'h0, 32'h00000055, 8'd12},
    '{1'b1, 8'h18, 32'h0000003F, 32'h0, 8'd6},
    '{1'b0, 8'h18, 32'h0, 32'h0000002B, 8'd7},   // R7 ip not set by sw, R6 load reads 0
    '{1'b0, 8'h10, 32'h0, 32'h12345678, 8'd6},   // R6 load copied reload
    '{1'b1, 8'h1C, 32'hDEADBEEF, 32'h0, 8'd8},
    '{1'b0, 8'h1C, 32'h0, 32'h12345678, 8'd8},   // R8 latch
    '{1'b0, 8'h0C, 32'h0, 32'h00000000, 8'd12},  // R12 unmapped
    '{1'b1, 8'h18, 32'h00000000, 32'h0, 8'd2},
    '{1'b0, 8'h2C, 32'h0, 32'h00000000, 8'd10}   // R10 timer 2 latch reset
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic run_count(input int n, output int c0, output int c1);
    c0 = 0; c1 = 0;
    for (int k = 0; k < n; k++) begin
      @(posedge clk); @(negedge clk);
      if (tmr_irq[0]) c0++;
      if (tmr_irq[1]) c1++;
    end
  endtask

  initial begin : main
    logic [31:0] v;
    int c0, c1, gap;
    // R10 reset values, read while reset is held
    repeat (3) @(negedge clk);
    rd(8'h00, v); check("R10", v, 32'd39);
    rd(8'h04, v); check("R10", v, 32'd39);
    rd(8'h18, v); check("R10", v, 32'd0);
    rd(8'h20, v); check("R10", v, 32'd0);
    check("R10", {30'd0, tmr_irq}, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < 18; i++) begin
      if (VEC[i].wr) wr(VEC[i].a, VEC[i].d);
      else begin
        rd(VEC[i].a, v);
        check($sformatf("R%0d", VEC[i].req), v, VEC[i].e);
      end
    end

    // R1 prescaler counts down once per clock
    wr(8'h00, 32'd100);
    rd(8'h00, v); check("R1", v, 32'd100);
    @(posedge clk); @(negedge clk);
    rd(8'h00, v); check("R1", v, 32'd99);

    // tick every clock from here
    wr(8'h04, 32'd0);
    wr(8'h00, 32'd0);

    // R3 restart: reload 2 -> underflow every 3 ticks, R11 pulses
    wr(8'h14, 32'd2);
    wr(8'h18, 32'h0000000F);
    run_count(12, c0, c1);
    check("R3", c0, 4);
    check("R11", c1, 0);
    rd(8'h18, v); check("R3", v, 32'h0000001B);
    wr(8'h18, 32'h0);
    rd(8'h18, v); check("R7", v, 32'h0);

    // R2 disabled timer holds
    wr(8'h10, 32'd7);
    run_count(5, c0, c1);
    rd(8'h10, v); check("R2", v, 32'd7);

    // R5 chained timer 2 blocked while timer 1 pending is 0
    wr(8'h20, 32'd3);
    wr(8'h28, 32'h00000021);
    run_count(10, c0, c1);
    rd(8'h20, v); check("R5", v, 32'd3);
    // timer 1 one-shot, no interrupt enable, sets its pending
    wr(8'h14, 32'd1);
    wr(8'h18, 32'h00000005);
    run_count(14, c0, c1);
    check("R11", c0 + c1, 0);
    rd(8'h28, v); check("R5", v, 32'h00000030);
    rd(8'h20, v); check("R4", v, 32'd0);
    rd(8'h18, v); check("R4", v, 32'h00000010);

    // R7 pending: write 1 keeps, write 0 clears, never set by software
    wr(8'h18, 32'h00000010);
    rd(8'h18, v); check("R7", v, 32'h00000010);
    wr(8'h18, 32'h00000000);
    rd(8'h18, v); check("R7", v, 32'h0);
    wr(8'h18, 32'h00000010);
    rd(8'h18, v); check("R7", v, 32'h0);

    // R4 one-shot with interrupt enable: single pulse, then stopped
    wr(8'h14, 32'd1);
    wr(8'h18, 32'h0000000D);
    run_count(8, c0, c1);
    check("R11", c0, 1);
    rd(8'h18, v); check("R4", v, 32'h00000018);
    rd(8'h10, v); check("R4", v, 32'd0);

    // R1 prescaler reload 4: tick every 5 clocks, reload 1 -> pulse every 10
    wr(8'h04, 32'd4);
    wr(8'h00, 32'd4);
    wr(8'h18, 32'h0000000F);
    for (int k = 0; k < 60 && !tmr_irq[0]; k++) begin
      @(posedge clk); @(negedge clk);
    end
    gap = 0;
    for (int k = 0; k < 60; k++) begin
      @(posedge clk); @(negedge clk);
      gap++;
      if (tmr_irq[0]) break;
    end
    check("R1", gap, 10);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule